// File: doc/BRIEF.md
# Per-User Page Map Translator

This block converts a program's 24-bit word address into a physical word address. It looks up the page number in a table of map registers for the running user. The low part of the address selects a word inside the page and reaches the output unchanged. The high part indexes the map table, and the stored physical page number replaces it. Translation is combinational, so a request arriving in a cycle leaves as a memory request in that same cycle with no added latency.

Four page sizes can be selected. Pages the user does not own are left pointing at physical page zero. Any reference that resolves to page zero is refused: the memory request is withheld, and one cycle later a fault pulse appears together with the virtual address that caused it. This gives isolation between users without a separate valid bit per entry. A synchronous write port loads map entries and the page-size code.

Top module: `pgmap_translator`

## Requirements
- R1: After reset every map entry is zero, the page size is 4K words and `fault` is low, so every request is refused until entries are loaded.
- R2: For a granted request, the low offset bits of `mem_paddr` equal those of `req_vaddr`. There are 12, 14, 16 or 18 offset bits for page-size codes 0, 1, 2 and 3 respectively.
- R3: For a granted request, the bits of `mem_paddr` above the offset hold the low (24 minus offset width) bits of the map entry selected by the request.
- R4: Translation is combinational. `mem_valid` and `mem_paddr` respond in the same cycle as `req_valid` and `req_vaddr`.
- R5: Page-size code 0, 1, 2 or 3 selects pages of 4K, 16K, 64K or 256K words. The map index is `req_vaddr` shifted right by the offset width, giving a 12-, 10-, 8- or 6-bit index.
- R6: At larger page sizes only the low map entries are reachable, and entry bits above the physical page number width are ignored. An entry whose used bits are zero is refused even when its upper bits are set.
- R7: A request whose resolved physical page number is zero is refused: `mem_valid` stays low.
- R8: One cycle after a refused request, `fault` is high for exactly that cycle and `fault_vaddr` carries the refused virtual address. In any other cycle `fault` is low.
- R9: A map-entry write (`cfg_map_we`) or a size write (`cfg_size_we`) takes effect from the following cycle.
- R10: While `req_valid` is low, `mem_valid` is low and no fault follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_map_we | input | 1 | Write strobe for a map entry |
| cfg_map_idx | input | 12 | Map entry index to write |
| cfg_map_ppn | input | 12 | Physical page number to store |
| cfg_size_we | input | 1 | Write strobe for the page-size code |
| cfg_size | input | 2 | Page-size code (0=4K, 1=16K, 2=64K, 3=256K) |
| req_valid | input | 1 | Access request |
| req_vaddr | input | 24 | Program-generated word address |
| mem_valid | output | 1 | Granted memory request |
| mem_paddr | output | 24 | Translated physical word address |
| fault | output | 1 | One-cycle refusal notification |
| fault_vaddr | output | 24 | Virtual address of the refused request |

## Verification
The assertions check these properties on every cycle. A grant only follows a request. A grant never targets page zero's first 4K words. The lowest 12 address bits always pass through. Each refusal is followed by exactly one fault cycle carrying the refused address, and no fault appears without one. The bench's scenarios are needed to show the rest: the page-number substitution, index selection and wider offsets at each page size, the masking of upper entry bits at large page sizes, and the one-cycle delay before a map or size write is seen.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;

    parameter int ADDR_W     = 24;
    parameter int BASE_OFF_W = 12;
    parameter int SIZE_STEP  = 2;

    localparam int IDX_W     = ADDR_W - BASE_OFF_W;
    localparam int MAP_DEPTH = 1 << IDX_W;
    localparam int SHIFT_W   = $clog2(ADDR_W + 1);

    typedef enum logic [1:0] {
        PG_4K   = 2'd0,
        PG_16K  = 2'd1,
        PG_64K  = 2'd2,
        PG_256K = 2'd3
    } pg_size_e;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [IDX_W-1:0]  ppn_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        logic  valid;
        addr_t vaddr;
    } fault_rec_t;

    function automatic logic [SHIFT_W-1:0] off_width(pg_size_e s);
        return SHIFT_W'(BASE_OFF_W + SIZE_STEP * int'(s));
    endfunction

endpackage

// File: rtl/pgmap_regfile.sv
module pgmap_regfile
    import pgmap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  idx_t     wr_idx,
    input  ppn_t     wr_data,
    input  logic     size_we,
    input  pg_size_e size_in,
    input  idx_t     rd_idx,
    output ppn_t     rd_data,
    output pg_size_e size_q
);

    ppn_t entries [MAP_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MAP_DEPTH; i++) entries[i] <= '0;
        end else if (wr_en) begin
            entries[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          size_q <= PG_4K;
        else if (size_we) size_q <= size_in;
    end

    assign rd_data = entries[rd_idx];

endmodule

// File: rtl/pgmap_xlate.sv
module pgmap_xlate
    import pgmap_pkg::*;
(
    input  addr_t    vaddr,
    input  pg_size_e size,
    output idx_t     idx,
    input  ppn_t     entry,
    output addr_t    paddr,
    output logic     deny
);

    logic [SHIFT_W-1:0] ow;
    logic [SHIFT_W-1:0] ppn_drop;
    addr_t              hi_mask;
    ppn_t               ppn_keep;
    ppn_t               ppn;

    assign ow       = off_width(size);
    assign ppn_drop = ow - SHIFT_W'(BASE_OFF_W);
    assign idx      = IDX_W'(vaddr >> ow);
    assign hi_mask  = {ADDR_W{1'b1}} << ow;
    assign ppn_keep = {IDX_W{1'b1}} >> ppn_drop;
    assign ppn      = entry & ppn_keep;
    assign deny     = (ppn == '0);
    assign paddr    = (ADDR_W'(ppn) << ow) | (vaddr & ~hi_mask);

endmodule

// File: rtl/pgmap_fault.sv
module pgmap_fault
    import pgmap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid,
    input  logic  deny,
    input  addr_t vaddr,
    output logic  fault,
    output addr_t fault_vaddr
);

    fault_rec_t rec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
        end else begin
            rec_q.valid <= req_valid & deny;
            if (req_valid & deny) rec_q.vaddr <= vaddr;
        end
    end

    assign fault       = rec_q.valid;
    assign fault_vaddr = rec_q.vaddr;

endmodule

// File: rtl/pgmap_translator.sv
module pgmap_translator
    import pgmap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_map_we,
    input  logic [11:0] cfg_map_idx,
    input  logic [11:0] cfg_map_ppn,
    input  logic        cfg_size_we,
    input  logic [1:0]  cfg_size,
    input  logic        req_valid,
    input  logic [23:0] req_vaddr,
    output logic        mem_valid,
    output logic [23:0] mem_paddr,
    output logic        fault,
    output logic [23:0] fault_vaddr
);

    pg_size_e size_q;
    idx_t     rd_idx;
    ppn_t     rd_entry;
    logic     deny;

    pgmap_regfile u_map (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_map_we),
        .wr_idx  (cfg_map_idx),
        .wr_data (cfg_map_ppn),
        .size_we (cfg_size_we),
        .size_in (pg_size_e'(cfg_size)),
        .rd_idx  (rd_idx),
        .rd_data (rd_entry),
        .size_q  (size_q)
    );

    pgmap_xlate u_xlate (
        .vaddr (req_vaddr),
        .size  (size_q),
        .idx   (rd_idx),
        .entry (rd_entry),
        .paddr (mem_paddr),
        .deny  (deny)
    );

    pgmap_fault u_fault (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .deny        (deny),
        .vaddr       (req_vaddr),
        .fault       (fault),
        .fault_vaddr (fault_vaddr)
    );

    assign mem_valid = req_valid & ~deny;

endmodule

// File: rtl/pgmap_translator_chk.sv
module pgmap_translator_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [23:0] req_vaddr,
    input logic        mem_valid,
    input logic [23:0] mem_paddr,
    input logic        fault,
    input logic [23:0] fault_vaddr
);

    // R1: fault is low in the first cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> !fault);

    // R2: the lowest 12 bits always pass through on a grant
    p_low_offset_r2: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_paddr[11:0] == req_vaddr[11:0]));

    // R7: a grant never lands in physical page zero
    p_grant_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_paddr[23:12] != 12'd0));

    // R10: no grant without a request
    p_grant_needs_req_r10: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> req_valid);

    // R8: a refusal produces a fault carrying its address next cycle
    p_fault_follows_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !mem_valid) |=> (fault && fault_vaddr == $past(req_vaddr)));

    // R8: no fault without a refusal in the previous cycle
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !mem_valid) |=> !fault);

endmodule

bind pgmap_translator pgmap_translator_chk u_chk (.*);

// File: tb/pgmap_translator_test.sv
module pgmap_translator_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_map_we = 1'b0;
    logic [11:0] cfg_map_idx = '0;
    logic [11:0] cfg_map_ppn = '0;
    logic        cfg_size_we = 1'b0;
    logic [1:0]  cfg_size = '0;
    logic        req_valid = 1'b0;
    logic [23:0] req_vaddr = '0;
    logic        mem_valid;
    logic [23:0] mem_paddr;
    logic        fault;
    logic [23:0] fault_vaddr;

    int nvec = 0;
    int nbad = 0;

    logic [11:0] mdl [4096];
    int          msize = 0;

    always #5 clk = ~clk;

    pgmap_translator uut (.*);

    function automatic int offw(int s);
        return 12 + 2 * s;
    endfunction

    function automatic logic [11:0] exp_ppn(logic [23:0] va);
        int ow = offw(msize);
        logic [11:0] ix = 12'(va >> ow);
        return mdl[ix] & (12'hFFF >> (ow - 12));
    endfunction

    function automatic logic [23:0] exp_paddr(logic [23:0] va);
        int ow = offw(msize);
        logic [23:0] lowm = ~(24'hFFFFFF << ow);
        return (24'(exp_ppn(va)) << ow) | (va & lowm);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic write_map(input logic [11:0] ix, input logic [11:0] d);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_map_we = 1'b1; cfg_map_idx = ix; cfg_map_ppn = d;
        @(posedge clk); #1;
        cfg_map_we = 1'b0;
        mdl[ix] = d;
    endtask

    task automatic write_size(input int s);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_size_we = 1'b1; cfg_size = 2'(s);
        @(posedge clk); #1;
        cfg_size_we = 1'b0;
        msize = s;
    endtask

    // drive a request, check the same-cycle grant and the next-cycle fault
    task automatic access(input logic [23:0] va, input string tag);
        logic deny_e;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va;
        #1;
        deny_e = (exp_ppn(va) == 12'd0);
        chk(mem_valid == !deny_e, {tag, " R4 R7 grant"}, 32'(mem_valid), 32'(!deny_e));
        if (!deny_e)
            chk(mem_paddr == exp_paddr(va), {tag, " R2 R3 paddr"}, 32'(mem_paddr), 32'(exp_paddr(va)));
        @(posedge clk); #1;
        chk(fault == deny_e, {tag, " R8 fault"}, 32'(fault), 32'(deny_e));
        if (deny_e)
            chk(fault_vaddr == va, {tag, " R8 fault addr"}, 32'(fault_vaddr), 32'(va));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4096; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk(fault == 1'b0, "R1 fault low after reset", 32'(fault), 0);

        // R1: unloaded map refuses everything
        access(24'h000000, "R1 zero addr");
        access(24'h123456, "R1 mid addr");
        access(24'hFFFFFF, "R1 top addr");

        // R3 R5: 4K pages, direct mapping
        write_map(12'h001, 12'hABC);
        access(24'h001234, "R3 4K hit");
        access(24'h002234, "R7 4K unmapped");

        // R9: write visible next cycle, overwrite to zero refuses
        write_map(12'h001, 12'h000);
        access(24'h001FFF, "R9 overwrite to zero");
        write_map(12'h001, 12'h7FF);
        access(24'h001000, "R9 reload");

        // R5 R6: 256K pages use index = top 6 bits and low 6 entry bits
        write_map(12'h005, 12'hFC0);
        write_size(3);
        access(24'h140000, "R6 upper bits ignored");
        write_map(12'h005, 12'hFC1);
        access(24'h17FFFF, "R6 256K hit");
        write_map(12'h03F, 12'h02A);
        access(24'hFC0001, "R5 256K last entry");

        // R5: 16K and 64K
        write_size(1);
        write_map(12'h3FF, 12'h3FF);
        access(24'hFFFFFF, "R5 16K top");
        write_size(2);
        write_map(12'h0FF, 12'h0F0);
        access(24'hFF8000, "R5 64K top");

        // R10: no request means no grant and no fault
        @(negedge clk);
        req_valid = 1'b0; req_vaddr = 24'hFF8000;
        #1;
        chk(mem_valid == 1'b0, "R10 idle no grant", 32'(mem_valid), 0);
        @(posedge clk); #1;
        chk(fault == 1'b0, "R10 idle no fault", 32'(fault), 0);

        // back-to-back refusals, each with its own address (R8)
        access(24'h000010, "R8 deny a");
        access(24'h000020, "R8 deny b");

        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            int pick = int'($urandom_range(0, 9));
            if (pick == 0) begin
                write_size(int'($urandom_range(0, 3)));
            end else if (pick <= 3) begin
                logic [11:0] d = 12'($urandom);
                if ($urandom_range(0, 3) == 0) d = '0;
                write_map(12'($urandom_range(0, 63)), d);
            end else begin
                logic [23:0] va = 24'($urandom);
                if ($urandom_range(0, 1) == 1)
                    va = va & ~(24'hFFFFFF << (offw(msize) + 6));
                access(va, "R2 R3 R5 random");
            end
        end

        @(negedge clk); req_valid = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule